// File: doc/BRIEF.md
# Event-Controlled Timer Counter Core

This block is an up/down counter whose starting, restarting and stepping are governed by a selectable action for one input event line. Software sets an enable bit and a direction bit and selects one of four event actions: none, retrigger, count and start. With no action the counter runs on the count-enable tick as soon as it is enabled. With the retrigger or start action, enabling only arms the counter, and an event or a software retrigger strobe starts it. With the count action, each event moves the counter by one step instead of the tick.

The counter width is selected at run time as 8, 16 or 32 bits. In 8-bit mode the counter wraps at a writable period value. In the wider modes it wraps at the all-ones value of that width. A one-cycle wrap pulse marks each overflow or underflow. A running flag reports whether the counter is actively counting. The event line is synchronous to the clock, and only its rising edge has an effect.

Top module: `evt_timer_core`

## Requirements
- R1: After synchronous reset the count is 0, the running flag is 0, the wrap pulse is 0 and the period register holds 8'hFF.
- R2: With event action 0 (none), the running flag goes to 1 on the first clock edge at which enable is high. From the next edge on, the count steps once per edge on which the tick is high. Event edges are ignored.
- R3: While enable is low, the running flag goes to 0 and the count holds its value.
- R4: With event action 1 (retrigger), enable alone leaves the counter stopped. An event rising edge or a software retrigger then starts it, and counting resumes from the value held, not from zero.
- R5: With event action 1 and the counter running, an event rising edge or a software retrigger reloads 0 when counting up (direction 0) and reloads the top value when counting down (direction 1).
- R6: With event action 2 (count), the tick is ignored. Each event rising edge moves the count by one, up for direction 0 and down for direction 1. An event held high counts only once.
- R7: With event action 3 (start), enable alone leaves the counter stopped. An event rising edge or a software retrigger starts it. Once it is running, events and software retriggers have no effect.
- R8: When counting up from a value at or above top, the next step gives 0 and raises the wrap output for exactly one cycle.
- R9: When counting down from 0, the next step gives the top value and raises the wrap output for exactly one cycle.
- R10: Width select 0 uses the period register as top, and the register is loaded when the period write strobe is high. Select 1 uses 16'hFFFF. Selects 2 and 3 use 32'hFFFFFFFF.
- R11: A retrigger reload takes priority over a tick step on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable tick |
| enable_i | input | 1 | Counter enable |
| dir_down_i | input | 1 | Direction: 0 up, 1 down |
| sw_retrig_i | input | 1 | Software retrigger strobe |
| event_i | input | 1 | Synchronous input event line |
| evact_i | input | 2 | Event action: 0 none, 1 retrigger, 2 count, 3 start |
| size_i | input | 2 | Width: 0 8-bit, 1 16-bit, 2/3 32-bit |
| period_we_i | input | 1 | Period register write strobe |
| period_d_i | input | 8 | Period register write data |
| count_o | output | 32 | Counter value |
| running_o | output | 1 | Counter actively counting |
| wrap_o | output | 1 | One-cycle overflow/underflow pulse |

## Verification
Each result is registered once. An event, a retrigger strobe, a tick or an enable change presented before a clock edge shows up in the count, the running flag and the wrap pulse right after that same edge. The one exception is the mode with no event action: there the running flag is set on the first enabled edge, so the first tick step lands one edge later. The bench drives inputs on the falling edge and reads outputs on the following falling edge, so each check reads exactly one edge after its stimulus. An event is held low for at least one edge between pulses so that every rising edge is seen as new.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int DEF_CNT_W = 32;
    localparam int DEF_PER_W = 8;

    typedef enum logic [1:0] {
        EVA_NONE    = 2'd0,
        EVA_RETRIG  = 2'd1,
        EVA_COUNT   = 2'd2,
        EVA_START   = 2'd3
    } evact_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_32B = 2'd3
    } size_e;

    typedef struct packed {
        logic restart;
        logic step;
    } cnt_cmd_t;

    function automatic logic starts_on_event(evact_e act);
        return (act == EVA_RETRIG) || (act == EVA_START);
    endfunction

endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/evt_run_ctrl.sv
module evt_run_ctrl
    import evt_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable_i,
    input  logic     tick_i,
    input  evact_e   evact_i,
    input  logic     evt_rise_i,
    input  logic     sw_retrig_i,
    output logic     run_o,
    output cnt_cmd_t cmd_o
);
    logic run_q;
    logic run_d;
    logic trig;

    assign trig = evt_rise_i | sw_retrig_i;

    always_comb begin
        run_d = 1'b0;
        if (enable_i) begin
            if (starts_on_event(evact_i)) run_d = run_q | trig;
            else                          run_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= run_d;
    end

    always_comb begin
        cmd_o.restart = enable_i && run_q && (evact_i == EVA_RETRIG) && trig;
        if (evact_i == EVA_COUNT) cmd_o.step = enable_i && evt_rise_i;
        else                      cmd_o.step = enable_i && run_q && tick_i;
    end

    assign run_o = run_q;

    // R7
    start_ignores_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (evact_i == EVA_START && run_q && enable_i) |=> run_q);

    // R4
    retrig_waits_chk: assert property (@(posedge clk) disable iff (rst)
        (evact_i == EVA_RETRIG && !run_q && !evt_rise_i && !sw_retrig_i) |=> !run_q);
endmodule

// File: rtl/evt_count_dp.sv
module evt_count_dp
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int PER_W = DEF_PER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  size_e            size_i,
    input  logic             dir_down_i,
    input  logic             period_we_i,
    input  logic [PER_W-1:0] period_d_i,
    input  cnt_cmd_t         cmd_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] MAX16 = CNT_W'((64'd1 << 16) - 64'd1);
    localparam logic [CNT_W-1:0] MAXW  = '1;

    logic [PER_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] top_w;
    logic             wrap_q;
    logic             wrap_d;

    always_ff @(posedge clk) begin
        if (rst)              period_q <= '1;
        else if (period_we_i) period_q <= period_d_i;
    end

    always_comb begin
        unique case (size_i)
            SZ_8:    top_w = CNT_W'(period_q);
            SZ_16:   top_w = MAX16;
            default: top_w = MAXW;
        endcase
    end

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        if (cmd_i.restart) begin
            cnt_d = dir_down_i ? top_w : '0;
        end else if (cmd_i.step) begin
            if (dir_down_i) begin
                if (cnt_q == '0) begin
                    cnt_d  = top_w;
                    wrap_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end else begin
                if (cnt_q >= top_w) begin
                    cnt_d  = '0;
                    wrap_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
        end
    end

    assign count_o = cnt_q;
    assign wrap_o  = wrap_q;

    // R8
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step && !cmd_i.restart && !dir_down_i && cnt_q >= top_w)
        |=> (cnt_q == '0 && wrap_q));

    // R9
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step && !cmd_i.restart && dir_down_i && cnt_q == '0)
        |=> (cnt_q == $past(top_w) && wrap_q));

    // R5
    reload_up_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.restart && !dir_down_i) |=> (cnt_q == '0));
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        enable_i,
    input  logic        dir_down_i,
    input  logic        sw_retrig_i,
    input  logic        event_i,
    input  logic [1:0]  evact_i,
    input  logic [1:0]  size_i,
    input  logic        period_we_i,
    input  logic [7:0]  period_d_i,
    output logic [31:0] count_o,
    output logic        running_o,
    output logic        wrap_o
);
    localparam int CNT_W = DEF_CNT_W;
    localparam int PER_W = DEF_PER_W;

    evact_e   act;
    size_e    sz;
    logic     evt_rise;
    cnt_cmd_t cmd;

    assign act = evact_e'(evact_i);
    assign sz  = size_e'(size_i);

    evt_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (event_i),
        .rise_o (evt_rise)
    );

    evt_run_ctrl u_run (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .tick_i      (tick_i),
        .evact_i     (act),
        .evt_rise_i  (evt_rise),
        .sw_retrig_i (sw_retrig_i),
        .run_o       (running_o),
        .cmd_o       (cmd)
    );

    evt_count_dp #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .size_i      (sz),
        .dir_down_i  (dir_down_i),
        .period_we_i (period_we_i),
        .period_d_i  (period_d_i),
        .cmd_i       (cmd),
        .count_o     (count_o),
        .wrap_o      (wrap_o)
    );

    // R3
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> ($stable(count_o) && !running_o));

    // R4
    resume_held_chk: assert property (@(posedge clk) disable iff (rst)
        (act == EVA_RETRIG && enable_i && !running_o && evt_rise) |=> $stable(count_o));
endmodule

// File: tb/evt_timer_core_bench.sv
`timescale 1ns/1ps
module evt_timer_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, en = 1'b0, dn = 1'b0, swr = 1'b0, evt = 1'b0;
    logic [1:0]  evact = 2'd0, size = 2'd0;
    logic        per_we = 1'b0;
    logic [7:0]  per_d = 8'd0;
    logic [31:0] count;
    logic        running, wrap;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    evt_timer_core u_evt_timer_core (
        .clk(clk), .rst(rst), .tick_i(tick), .enable_i(en), .dir_down_i(dn),
        .sw_retrig_i(swr), .event_i(evt), .evact_i(evact), .size_i(size),
        .period_we_i(per_we), .period_d_i(per_d),
        .count_o(count), .running_o(running), .wrap_o(wrap)
    );

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 0; en = 0; dn = 0; swr = 0; evt = 0;
        evact = 0; size = 0; per_we = 0; per_d = 0;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic pulse_evt();
        evt = 1'b1; cyc(1); evt = 1'b0;
    endtask

    task automatic pulse_sw();
        swr = 1'b1; cyc(1); swr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 running", {31'd0, running}, 0);
        chk("R1 wrap", {31'd0, wrap}, 0);
    endtask

    task automatic t_none();
        do_reset();
        evact = 2'd0; size = 2'd1; tick = 1; en = 1;
        cyc(1);
        chk("R2 running", {31'd0, running}, 1);
        chk("R2 first", count, 0);
        cyc(1);
        chk("R2 step", count, 1);
        pulse_evt();
        chk("R2 event ignored", count, 2);
        tick = 0; cyc(3);
        chk("R2 no tick", count, 2);
        tick = 1; cyc(2);
        chk("R2 resume", count, 4);
        en = 0; cyc(1);
        chk("R3 stopped", {31'd0, running}, 0);
        chk("R3 held", count, 4);
    endtask

    task automatic t_retrig();
        do_reset();
        evact = 2'd1; size = 2'd0; per_we = 1; per_d = 8'd10;
        cyc(1);
        per_we = 0; tick = 1; en = 1;
        cyc(3);
        chk("R4 armed only", {31'd0, running}, 0);
        chk("R4 armed count", count, 0);
        pulse_evt();
        chk("R4 started", {31'd0, running}, 1);
        chk("R4 start value", count, 0);
        cyc(4);
        chk("R4 counting", count, 4);
        en = 0; cyc(1);
        chk("R3 stop", {31'd0, running}, 0);
        chk("R3 hold", count, 4);
        cyc(2);
        chk("R3 hold long", count, 4);
        en = 1; cyc(2);
        chk("R4 re-enable stays stopped", {31'd0, running}, 0);
        pulse_evt();
        chk("R4 resumed", {31'd0, running}, 1);
        chk("R4 held value", count, 4);
        cyc(1);
        chk("R4 continues", count, 5);
        pulse_evt();
        chk("R5 R11 reload up", count, 0);
        dn = 1; pulse_sw();
        chk("R5 reload down to period", count, 10);
        cyc(1);
        chk("R5 counts down", count, 9);
    endtask

    task automatic t_count();
        do_reset();
        evact = 2'd2; size = 2'd1; tick = 1; en = 1;
        cyc(3);
        chk("R6 tick ignored", count, 0);
        pulse_evt();
        chk("R6 one event", count, 1);
        cyc(1);
        evt = 1; cyc(3); evt = 0;
        chk("R6 level once", count, 2);
        cyc(1);
        dn = 1; pulse_evt();
        chk("R6 down", count, 1);
        cyc(1); pulse_evt();
        chk("R6 down to zero", count, 0);
        cyc(1); pulse_evt();
        chk("R9 R10 16-bit underflow", count, 32'hFFFF);
        chk("R9 wrap pulse", {31'd0, wrap}, 1);
        cyc(1);
        chk("R9 wrap one cycle", {31'd0, wrap}, 0);
        chk("R9 value kept", count, 32'hFFFF);
    endtask

    task automatic t_start();
        do_reset();
        evact = 2'd3; size = 2'd0; tick = 1; en = 1;
        cyc(3);
        chk("R7 not started", {31'd0, running}, 0);
        chk("R7 idle count", count, 0);
        pulse_sw();
        chk("R7 sw start", {31'd0, running}, 1);
        cyc(3);
        chk("R7 counting", count, 3);
        pulse_evt();
        chk("R7 event no effect", count, 4);
        pulse_sw();
        chk("R7 sw no effect", count, 5);
        chk("R7 still running", {31'd0, running}, 1);
        do_reset();
        evact = 2'd3; tick = 1; en = 1;
        cyc(1);
        pulse_evt();
        chk("R7 event start", {31'd0, running}, 1);
    endtask

    task automatic t_wrap();
        do_reset();
        size = 2'd0; per_we = 1; per_d = 8'd3;
        cyc(1);
        per_we = 0; evact = 2'd0; tick = 1; en = 1;
        cyc(1);
        cyc(3);
        chk("R8 at top", count, 3);
        chk("R8 no wrap yet", {31'd0, wrap}, 0);
        cyc(1);
        chk("R8 R10 wrap to zero", count, 0);
        chk("R8 wrap pulse", {31'd0, wrap}, 1);
        cyc(1);
        chk("R8 pulse ends", {31'd0, wrap}, 0);
        chk("R8 after wrap", count, 1);
        do_reset();
        size = 2'd2; dn = 1; tick = 1; en = 1;
        cyc(2);
        chk("R9 R10 32-bit underflow", count, 32'hFFFFFFFF);
        chk("R9 wrap 32", {31'd0, wrap}, 1);
        cyc(1);
        chk("R9 down after", count, 32'hFFFFFFFE);
        do_reset();
        size = 2'd0; dn = 1; tick = 1; en = 1;
        cyc(2);
        chk("R1 R10 default period", count, 32'hFF);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_none();
        t_retrig();
        t_count();
        t_start();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule